// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block lets each CPU of a multi-core cluster raise numbered doorbell events on any chosen group of CPUs. A single store to the shared trigger offset names one doorbell and a bitmap of target CPUs. Every targeted CPU then latches that doorbell in its own pending (cause) register. Each CPU also owns an enable (mask) register. A per-CPU summary line is raised while any enabled doorbell is pending. The interrupt controller reports that line as interrupt ID 0.

Every CPU has its own access port into the unit, so several CPUs may store in the same cycle. Cause and mask accesses are banked: each port reaches the registers of the CPU that owns it. Pending bits are cleared by writing zeros. Bits written as ones are left untouched, so a handler can clear exactly the doorbells it has read.

Top module: `dbell_unit`

## Requirements
- R1: After synchronous reset every cause register and every mask register is 0, all summary lines are low and no read response is pending.
- R2: A write at offset 0x04 carries the doorbell number in bits [4:0] and the target bitmap from bit 8 upward (bit 8+c selects CPU c). For every targeted CPU, the cause bit with that number reads 1 after the write edge.
- R3: Trigger bits [7:5] and bitmap bits for CPUs beyond N_CPU are ignored. A trigger whose bitmap names no present CPU changes no register.
- R4: A write at offset 0x08 clears each of the port's own cause bits written as 0 and keeps each bit written as 1. A cause bit never becomes 1 except through a trigger.
- R5: Offset 0x0C is the port's own 32-bit mask register; it is read and written in full, and a 1 enables the doorbell with that bit number.
- R6: Summary line c is high exactly while CPU c has a cause bit that is also enabled in its mask, from the edge that changed either register.
- R7: When a trigger sets a cause bit in the same cycle as a clearing write to that register, the bit ends up set.
- R8: Triggers issued by several ports in one cycle all take effect; their bits are combined.
- R9: A read returns the port's own cause (0x08) or mask (0x0C) as it stood before that edge, with rd_valid high, in the cycle after the request. Any other offset reads 0, and reads change no state.
- R10: Writes to any offset other than 0x04, 0x08 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CPU | Access request, one bit per CPU port |
| req_write | input | N_CPU | 1 = write, 0 = read, per port |
| req_addr | input | N_CPU x 8 | Byte offset per port |
| req_wdata | input | N_CPU x 32 | Write data per port |
| rd_valid | output | N_CPU | Read response valid, per port |
| rd_data | output | N_CPU x 32 | Read response data, per port |
| db_pending | output | N_CPU | Per-CPU doorbell summary |

## Verification
Every register update lands on the edge that samples the write. The cause and mask values, and the summary lines derived from them, are therefore due one cycle after a write request. A read response appears one edge after its request and carries the register value from before that edge. The bench drives requests on the falling edge and advances a behavioural model on the rising edge. It then compares summaries and read responses to the model on the next falling edge, which is exactly one register stage later. Directed reads add fixed expected values for the set, clear, collision and ignore cases.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_W   = $clog2(REG_W);
    localparam int TGT_LSB = 8;

    localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h0C;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_TRIG,
        ACC_CAUSE,
        ACC_MASK
    } acc_kind_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_TRIG:  return ACC_TRIG;
            OFS_CAUSE: return ACC_CAUSE;
            OFS_MASK:  return ACC_MASK;
            default:   return ACC_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] bit_of(input logic [NUM_W-1:0] n);
        return REG_W'(1) << n;
    endfunction
endpackage

// File: rtl/dbell_trig_decode.sv
module dbell_trig_decode
    import dbell_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  bus_req_t [N_CPU-1:0]            req,
    output logic     [N_CPU-1:0][REG_W-1:0] set_vec
);
    logic [N_CPU-1:0]            is_trig;
    logic [N_CPU-1:0][REG_W-1:0] num_bit;

    for (genvar s = 0; s < N_CPU; s++) begin : g_src
        assign is_trig[s] = req[s].valid && req[s].write &&
                            (classify(req[s].addr) == ACC_TRIG);
        assign num_bit[s] = bit_of(req[s].wdata[NUM_W-1:0]);
    end

    always_comb begin
        set_vec = '0;
        for (int t = 0; t < N_CPU; t++) begin
            for (int s = 0; s < N_CPU; s++) begin
                if (is_trig[s] && req[s].wdata[TGT_LSB+t])
                    set_vec[t] = set_vec[t] | num_bit[s];
            end
        end
    end
endmodule

// File: rtl/dbell_cpu_bank.sv
module dbell_cpu_bank
    import dbell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [REG_W-1:0] set_bits,
    output logic             pending,
    output logic             rd_valid,
    output logic [REG_W-1:0] rd_data
);
    acc_kind_e        kind;
    logic             wr_cause, wr_mask, rd_req;
    logic [REG_W-1:0] keep, cause, mask;

    assign kind     = classify(req.addr);
    assign wr_cause = req.valid && req.write && (kind == ACC_CAUSE);
    assign wr_mask  = req.valid && req.write && (kind == ACC_MASK);
    assign rd_req   = req.valid && !req.write;
    assign keep     = wr_cause ? req.wdata : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause    <= '0;
            mask     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            cause    <= (cause & keep) | set_bits;
            if (wr_mask) mask <= req.wdata;
            rd_valid <= rd_req;
            if (rd_req) begin
                case (kind)
                    ACC_CAUSE: rd_data <= cause;
                    ACC_MASK:  rd_data <= mask;
                    default:   rd_data <= '0;
                endcase
            end
        end
    end

    assign pending = |(cause & mask);

    // R2 / R7: a requested set always lands, even against a clear
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0) |=> ((cause & $past(set_bits)) == $past(set_bits)));

    // R4: no cause bit rises without a trigger
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause & ~$past(cause) & ~$past(set_bits)) == '0));

    // R4: zeros written to cause are gone after the edge
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_cause && set_bits == '0) |=> ((cause & ~$past(req.wdata)) == '0));

    // R5: mask only moves on a mask write
    a_r5_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_mask |=> $stable(mask));
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
    import dbell_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_CPU-1:0]                req_valid,
    input  logic [N_CPU-1:0]                req_write,
    input  logic [N_CPU-1:0][ADDR_W-1:0]    req_addr,
    input  logic [N_CPU-1:0][REG_W-1:0]     req_wdata,
    output logic [N_CPU-1:0]                rd_valid,
    output logic [N_CPU-1:0][REG_W-1:0]     rd_data,
    output logic [N_CPU-1:0]                db_pending
);
    bus_req_t [N_CPU-1:0]            req;
    logic     [N_CPU-1:0][REG_W-1:0] set_vec;

    for (genvar c = 0; c < N_CPU; c++) begin : g_pack
        assign req[c].valid = req_valid[c];
        assign req[c].write = req_write[c];
        assign req[c].addr  = req_addr[c];
        assign req[c].wdata = req_wdata[c];
    end

    dbell_trig_decode #(.N_CPU(N_CPU)) u_dec (
        .req     (req),
        .set_vec (set_vec)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_bank
        dbell_cpu_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .req      (req[c]),
            .set_bits (set_vec[c]),
            .pending  (db_pending[c]),
            .rd_valid (rd_valid[c]),
            .rd_data  (rd_data[c])
        );
    end
endmodule

// File: tb/sim_dbell_unit.sv
module sim_dbell_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0]           req_valid = '0;
    logic [NC-1:0]           req_write = '0;
    logic [NC-1:0][7:0]      req_addr  = '0;
    logic [NC-1:0][31:0]     req_wdata = '0;
    logic [NC-1:0]           rd_valid;
    logic [NC-1:0][31:0]     rd_data;
    logic [NC-1:0]           db_pending;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit started = 0;
    bit finished = 0;

    logic [31:0] m_cause [NC];
    logic [31:0] m_mask  [NC];
    logic [31:0] m_set   [NC];
    logic        e_rdv   [NC];
    logic [31:0] e_rdd   [NC];

    dbell_unit #(.N_CPU(NC)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .db_pending(db_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NC; c++) begin
                m_cause[c] = 0; m_mask[c] = 0; e_rdv[c] = 0; e_rdd[c] = 0;
            end
        end else begin
            for (int c = 0; c < NC; c++) m_set[c] = 0;
            for (int s = 0; s < NC; s++)
                if (req_valid[s] && req_write[s] && req_addr[s] == 8'h04)
                    for (int t = 0; t < NC; t++)
                        if (req_wdata[s][8+t]) m_set[t][req_wdata[s][4:0]] = 1'b1;
            for (int c = 0; c < NC; c++) begin
                e_rdv[c] = req_valid[c] && !req_write[c];
                if (e_rdv[c])
                    e_rdd[c] = (req_addr[c] == 8'h08) ? m_cause[c] :
                               (req_addr[c] == 8'h0C) ? m_mask[c] : 32'h0;
                if (req_valid[c] && req_write[c] && req_addr[c] == 8'h08)
                    m_cause[c] = m_cause[c] & req_wdata[c];
                m_cause[c] = m_cause[c] | m_set[c];
                if (req_valid[c] && req_write[c] && req_addr[c] == 8'h0C)
                    m_mask[c] = req_wdata[c];
            end
        end
        started = 1;
    end

    // per-cycle comparison one register stage after the model step
    always @(negedge clk) begin
        if (started && !finished) begin
            for (int c = 0; c < NC; c++) begin
                check("R6 summary", {31'b0, db_pending[c]}, {31'b0, |(m_cause[c] & m_mask[c])});
                check("R9 rd_valid", {31'b0, rd_valid[c]}, {31'b0, e_rdv[c]});
                if (e_rdv[c]) check("R9 rd_data", rd_data[c], e_rdd[c]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid[p] = 1; req_write[p] = 1; req_addr[p] = a; req_wdata[p] = d;
        @(negedge clk);
        req_valid = '0; req_write = '0;
    endtask

    task automatic rd(input int p, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid[p] = 1; req_write[p] = 0; req_addr[p] = a;
        @(negedge clk);
        req_valid = '0;
        d = rd_data[p];
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 summary", {28'b0, db_pending}, 32'h0);
        rd(0, 8'h08, v); check("R1 cause0", v, 32'h0);
        rd(3, 8'h0C, v); check("R1 mask3", v, 32'h0);

        for (int c = 0; c < NC; c++) wr(c, 8'h0C, 32'hFF);
        rd(2, 8'h0C, v); check("R5 mask2", v, 32'hFF);

        wr(1, 8'h04, 32'h0000_0503);
        rd(0, 8'h08, v); check("R2 cause0", v, 32'h8);
        rd(2, 8'h08, v); check("R2 cause2", v, 32'h8);
        rd(1, 8'h08, v); check("R2 cause1", v, 32'h0);
        check("R6 pend", {28'b0, db_pending}, 32'h5);

        wr(0, 8'h04, 32'hFFFF_F0E5);
        rd(1, 8'h08, v); check("R3 ghost bitmap", v, 32'h0);
        rd(3, 8'h08, v); check("R3 ghost bitmap", v, 32'h0);
        wr(0, 8'h04, 32'h0000_F2E6);
        rd(1, 8'h08, v); check("R3 high num bits", v, 32'h40);

        wr(2, 8'h04, 32'h0000_081F);
        rd(3, 8'h08, v); check("R2 num31", v, 32'h8000_0000);
        check("R6 masked", {31'b0, db_pending[3]}, 32'h0);
        wr(3, 8'h0C, 32'h8000_0000);
        check("R6 enabled", {31'b0, db_pending[3]}, 32'h1);

        wr(0, 8'h08, 32'hFFFF_FFF7);
        rd(0, 8'h08, v); check("R4 clear", v, 32'h0);
        check("R4 pend0", {31'b0, db_pending[0]}, 32'h0);
        wr(1, 8'h08, 32'hFFFF_FFFF);
        rd(1, 8'h08, v); check("R4 ones keep", v, 32'h40);

        @(negedge clk);
        req_valid = 4'b0101; req_write = 4'b0101;
        req_addr[0] = 8'h04; req_wdata[0] = 32'h0000_0401;
        req_addr[2] = 8'h08; req_wdata[2] = 32'h0;
        @(negedge clk);
        req_valid = '0; req_write = '0;
        rd(2, 8'h08, v); check("R7 set wins", v, 32'h2);

        @(negedge clk);
        req_valid = 4'b1001; req_write = 4'b1001;
        req_addr[0] = 8'h04; req_wdata[0] = 32'h0000_0200;
        req_addr[3] = 8'h04; req_wdata[3] = 32'h0000_0207;
        @(negedge clk);
        req_valid = '0; req_write = '0;
        rd(1, 8'h08, v); check("R8 combined", v, 32'hC1);

        rd(1, 8'h04, v); check("R9 trig reads 0", v, 32'h0);
        rd(1, 8'h10, v); check("R9 other reads 0", v, 32'h0);
        rd(1, 8'h08, v); check("R9 no side effect", v, 32'hC1);

        wr(1, 8'h00, 32'h0);
        wr(1, 8'h10, 32'h0);
        rd(1, 8'h08, v); check("R10 cause kept", v, 32'hC1);
        rd(1, 8'h0C, v); check("R10 mask kept", v, 32'hFF);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule